// File: doc/BRIEF.md
# Half-Duplex Collision and Jabber Monitor

This block sits beside the transmit and receive paths of a 10/100 Ethernet physical layer and produces the two status lines a MAC uses to arbitrate a shared medium: a collision flag and a carrier-sense flag. Both are formed from the MAC's transmit enable and a receive-activity flag supplied by the receive path. The duplex setting decides whether the block's own transmissions count as carrier and whether overlapping traffic is reported as a collision.

In 10 Mb/s operation a watchdog counts how long transmit enable stays high. A transmission that runs past the limit is cut off: the block raises a transmit-block output and holds the collision flag high. That state is held until transmit enable has stayed low for a long quiet interval. A control input turns the watchdog off. After each half-duplex 10 Mb/s transmission the block also raises a single-cycle request for the signal-quality heartbeat pulse, a fixed number of cycles after the end of the frame.

All limits are counts of the block clock and are set by parameters, so a test can use short values. The default values stand for roughly 24 ms and 0.5 s at 25 MHz.

Top module: `hdx_colmon`

## Requirements
- R1: While `rst` is high at a rising edge, and after that edge with all inputs low, `col`, `crs`, `tx_block` and `sqe_req` are all 0.
- R2: In half duplex (`full_duplex`=0) with no jabber latched, `col` is 1 in exactly those cycles where `tx_en` and `rx_active` are both 1, in the same cycle and with no register delay.
- R3: In full duplex (`full_duplex`=1) `col` stays 0 whatever `tx_en` and `rx_active` do, unless a jabber is latched.
- R4: `crs` equals `rx_active` OR `tx_en` in half duplex, and equals `rx_active` alone in full duplex, in the same cycle.
- R5: With `speed_100`=0 and `jab_disable`=0, `tx_block` rises right after the JAB_LIMIT-th consecutive rising edge that samples `tx_en` high. A run of JAB_LIMIT-1 such edges followed by a low sample does not set it.
- R6: While `tx_block` is 1, `col` is 1 whatever the values of `rx_active` and `full_duplex`.
- R7: A latched jabber clears right after the UNJAB_LIMIT-th consecutive rising edge that samples `tx_en` low. Any high sample restarts that count.
- R8: With `jab_disable`=1 no jabber is ever latched, and a latched jabber clears right after the first edge that samples `jab_disable`=1.
- R9: With `speed_100`=1 no jabber timeout occurs, however long `tx_en` stays high.
- R10: In half-duplex 10 Mb/s with no jabber latched, `sqe_req` is 1 for exactly the one cycle that follows the SQE_DELAY-th rising edge after the first edge that samples `tx_en` low following a high sample.
- R11: No `sqe_req` pulse is produced if `full_duplex` or `speed_100` is 1 while the delay runs, or if `tx_en` returns high before the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable from the MAC |
| rx_active | input | 1 | Receive activity flag from the receive path |
| full_duplex | input | 1 | 1 selects full duplex, 0 half duplex |
| speed_100 | input | 1 | 1 selects 100 Mb/s, 0 selects 10 Mb/s |
| jab_disable | input | 1 | 1 turns off the jabber watchdog and releases a latched jabber |
| col | output | 1 | Collision indication to the MAC |
| crs | output | 1 | Carrier sense indication to the MAC |
| tx_block | output | 1 | 1 while the transmitter is shut off by the jabber watchdog |
| sqe_req | output | 1 | Single-cycle request for the heartbeat test pulse |

## Verification
A wrong jabber state shows at the ports at once. A latch that sets one edge early or late, or a quiet count that does not restart, moves the edges of `tx_block` and `col` by that cycle, so a cycle-exact comparison exposes it within one clock. A stale SQE delay count shows as a pulse in the wrong cycle or after a cancelled interval, on the cycle it is due. Mode errors in the status mux appear on `col` and `crs` in the same cycle the inputs change. For that reason every cycle of the stimulus is compared, not just the end points.

// File: rtl/hdx_colmon_pkg.sv
`timescale 1ns/1ps
package hdx_colmon_pkg;

    // Watchdog state of the 10 Mb/s transmitter.
    typedef enum logic {
        JAB_CLEAR   = 1'b0,
        JAB_LATCHED = 1'b1
    } jab_state_e;

    // Static link configuration, sampled every cycle.
    typedef struct packed {
        logic full_duplex;
        logic fast;
        logic jab_inhibit;
    } link_cfg_t;

    // Status pair handed to the MAC.
    typedef struct packed {
        logic col;
        logic crs;
    } mac_status_t;

    // Bits needed to hold the values 0 .. limit-1.
    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

    // Heartbeat pulses only exist on a shared 10 Mb/s medium.
    function automatic logic is_hdx10(input logic fdx, input logic fast);
        return !fdx && !fast;
    endfunction

endpackage

// File: rtl/hdx_run_timer.sv
`timescale 1ns/1ps
module hdx_run_timer
    import hdx_colmon_pkg::*;
#(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);
    // expire is high on the LIMIT-th consecutive cycle with run high.
    generate
        if (LIMIT <= 1) begin : g_direct
            assign expire = run;
        end else begin : g_count
            localparam int unsigned W = cnt_width(LIMIT);
            localparam logic [W-1:0] LAST = W'(LIMIT - 1);
            localparam logic [W-1:0] STEP = W'(1);

            logic [W-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    cnt <= '0;
                end else if (cnt != LAST) begin
                    cnt <= cnt + STEP;
                end
            end

            assign expire = run && (cnt == LAST);
        end
    endgenerate

endmodule

// File: rtl/hdx_jab_ctrl.sv
`timescale 1ns/1ps
module hdx_jab_ctrl
    import hdx_colmon_pkg::*;
#(
    parameter int unsigned JAB_LIMIT   = 600000,
    parameter int unsigned UNJAB_LIMIT = 12500000
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    input  logic fast,
    input  logic inhibit,
    output logic jabbed
);
    jab_state_e state;
    logic run_on, run_off, exp_on, exp_off;

    // Over-length count: only in 10 Mb/s, only while enabled.
    assign run_on  = (state == JAB_CLEAR) && tx_en && !fast && !inhibit;
    // Quiet count: transmit enable must stay low the whole interval.
    assign run_off = (state == JAB_LATCHED) && !tx_en && !inhibit;

    hdx_run_timer #(.LIMIT(JAB_LIMIT)) u_on_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (run_on),
        .expire (exp_on)
    );

    hdx_run_timer #(.LIMIT(UNJAB_LIMIT)) u_off_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (run_off),
        .expire (exp_off)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= JAB_CLEAR;
        end else begin
            case (state)
                JAB_CLEAR:   if (exp_on)             state <= JAB_LATCHED;
                JAB_LATCHED: if (inhibit || exp_off) state <= JAB_CLEAR;
                default:                             state <= JAB_CLEAR;
            endcase
        end
    end

    assign jabbed = (state == JAB_LATCHED);

    // R5
    jab_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(jabbed) |-> ($past(tx_en) && !$past(fast) && !$past(inhibit)));

    // R7
    jab_rel_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(jabbed) |-> (!$past(tx_en) || $past(inhibit)));

    // R8
    jab_inh_chk: assert property (@(posedge clk) disable iff (rst)
        inhibit |=> !jabbed);

endmodule

// File: rtl/hdx_sqe_gen.sv
`timescale 1ns/1ps
module hdx_sqe_gen
    import hdx_colmon_pkg::*;
#(
    parameter int unsigned DELAY = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    input  logic fdx,
    input  logic fast,
    input  logic jabbed,
    output logic sqe_req
);
    localparam int unsigned W = cnt_width(DELAY);
    localparam logic [W-1:0] LAST = W'(DELAY - 1);
    localparam logic [W-1:0] STEP = W'(1);

    logic         tx_q;
    logic         armed;
    logic [W-1:0] cnt;
    logic         pulse;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q  <= 1'b0;
            armed <= 1'b0;
            cnt   <= '0;
            pulse <= 1'b0;
        end else begin
            tx_q  <= tx_en;
            pulse <= 1'b0;
            if (!is_hdx10(fdx, fast) || tx_en || jabbed) begin
                armed <= 1'b0;
            end else if (tx_q) begin
                // first low sample after a frame
                armed <= 1'b1;
                cnt   <= '0;
            end else if (armed) begin
                if (cnt == LAST) begin
                    pulse <= 1'b1;
                    armed <= 1'b0;
                end else begin
                    cnt <= cnt + STEP;
                end
            end
        end
    end

    assign sqe_req = pulse;

    // R10
    sqe_single_chk: assert property (@(posedge clk) disable iff (rst)
        sqe_req |=> !sqe_req);

    // R11
    sqe_mode_chk: assert property (@(posedge clk) disable iff (rst)
        sqe_req |-> (!$past(fdx) && !$past(fast) && !$past(tx_en)));

endmodule

// File: rtl/hdx_status_mux.sv
`timescale 1ns/1ps
module hdx_status_mux
    import hdx_colmon_pkg::*;
(
    input  logic        tx_en,
    input  logic        rx_active,
    input  logic        fdx,
    input  logic        jabbed,
    output mac_status_t status
);
    always_comb begin
        status.col = jabbed || (!fdx && tx_en && rx_active);
        status.crs = rx_active || (!fdx && tx_en);
    end

    // R4
    always_comb begin
        if (!fdx && tx_en) crs_own_chk: assert (status.crs);
    end

endmodule

// File: rtl/hdx_colmon.sv
`timescale 1ns/1ps
module hdx_colmon
    import hdx_colmon_pkg::*;
#(
    parameter int unsigned JAB_LIMIT   = 600000,
    parameter int unsigned UNJAB_LIMIT = 12500000,
    parameter int unsigned SQE_DELAY   = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    input  logic rx_active,
    input  logic full_duplex,
    input  logic speed_100,
    input  logic jab_disable,
    output logic col,
    output logic crs,
    output logic tx_block,
    output logic sqe_req
);
    link_cfg_t   cfg;
    mac_status_t status;
    logic        jabbed;

    assign cfg = '{full_duplex: full_duplex, fast: speed_100, jab_inhibit: jab_disable};

    hdx_jab_ctrl #(
        .JAB_LIMIT   (JAB_LIMIT),
        .UNJAB_LIMIT (UNJAB_LIMIT)
    ) u_jab (
        .clk     (clk),
        .rst     (rst),
        .tx_en   (tx_en),
        .fast    (cfg.fast),
        .inhibit (cfg.jab_inhibit),
        .jabbed  (jabbed)
    );

    hdx_sqe_gen #(.DELAY(SQE_DELAY)) u_sqe (
        .clk     (clk),
        .rst     (rst),
        .tx_en   (tx_en),
        .fdx     (cfg.full_duplex),
        .fast    (cfg.fast),
        .jabbed  (jabbed),
        .sqe_req (sqe_req)
    );

    hdx_status_mux u_status (
        .tx_en     (tx_en),
        .rx_active (rx_active),
        .fdx       (cfg.full_duplex),
        .jabbed    (jabbed),
        .status    (status)
    );

    assign col      = status.col;
    assign crs      = status.crs;
    assign tx_block = jabbed;

    // R3
    fdx_col_chk: assert property (@(posedge clk) disable iff (rst)
        (full_duplex && !tx_block) |-> !col);

    // R6
    jab_col_chk: assert property (@(posedge clk) disable iff (rst)
        tx_block |-> col);

    // R4
    crs_rx_chk: assert property (@(posedge clk) disable iff (rst)
        rx_active |-> crs);

    // R2
    hdx_col_chk: assert property (@(posedge clk) disable iff (rst)
        (!full_duplex && tx_en && rx_active) |-> col);

endmodule

// File: tb/hdx_colmon_bench.sv
`timescale 1ns/1ps
module hdx_colmon_bench;
    localparam int JL = 20;
    localparam int UL = 30;
    localparam int SD = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1, tx_en = 1'b0, rx_active = 1'b0;
    logic full_duplex = 1'b0, speed_100 = 1'b0, jab_disable = 1'b0;
    logic col, crs, tx_block, sqe_req;

    hdx_colmon #(.JAB_LIMIT(JL), .UNJAB_LIMIT(UL), .SQE_DELAY(SD)) u_hdx_colmon (
        .clk(clk), .rst(rst), .tx_en(tx_en), .rx_active(rx_active),
        .full_duplex(full_duplex), .speed_100(speed_100), .jab_disable(jab_disable),
        .col(col), .crs(crs), .tx_block(tx_block), .sqe_req(sqe_req)
    );

    int n_chk = 0, n_err = 0;

    // Scoreboard: {col, crs, tx_block, sqe_req} per cycle, with requirement tag.
    logic [3:0] q_val[$];
    string      q_tag[$];

    // Reference state derived from the requirements.
    bit p_tx = 0, p_rx = 0, p_fdx = 0, p_spd = 0, p_dis = 0, p_rs = 1;
    bit m_jab = 0, m_sqe = 0, m_txq = 0;
    int hi = 0, lo = 0, wait_n = -1;

    task automatic model_edge();
        bit jab_before;
        jab_before = m_jab;
        if (p_rs) begin
            m_jab = 0; m_sqe = 0; m_txq = 0; hi = 0; lo = 0; wait_n = -1;
        end else begin
            m_sqe = 0;
            if (p_fdx || p_spd || p_tx || jab_before) wait_n = -1;
            else if (m_txq) wait_n = 0;
            else if (wait_n >= 0) begin
                if (wait_n == SD - 1) begin m_sqe = 1; wait_n = -1; end
                else wait_n++;
            end
            m_txq = p_tx;
            if (!jab_before) begin
                if (p_tx && !p_spd && !p_dis) hi++; else hi = 0;
                if (hi == JL) begin m_jab = 1; hi = 0; lo = 0; end
            end else begin
                if (p_dis) m_jab = 0;
                else begin
                    if (!p_tx) lo++; else lo = 0;
                    if (lo == UL) m_jab = 0;
                end
                if (!m_jab) lo = 0;
            end
        end
    endtask

    // Driver: one cycle of stimulus plus the expected outputs for it.
    task automatic step(input bit tx, input bit rx, input bit fdx, input bit spd,
                        input bit dis, input bit rs, input string tag);
        bit ecol, ecrs;
        @(posedge clk);
        model_edge();
        #1;
        tx_en = tx; rx_active = rx; full_duplex = fdx;
        speed_100 = spd; jab_disable = dis; rst = rs;
        p_tx = tx; p_rx = rx; p_fdx = fdx; p_spd = spd; p_dis = dis; p_rs = rs;
        ecol = m_jab || (!fdx && tx && rx);
        ecrs = rx || (!fdx && tx);
        q_val.push_back({ecol, ecrs, m_jab, m_sqe});
        q_tag.push_back(tag);
    endtask

    task automatic hold(input int n, input bit tx, input bit rx, input bit fdx,
                        input bit spd, input bit dis, input string tag);
        for (int i = 0; i < n; i++) step(tx, rx, fdx, spd, dis, 1'b0, tag);
    endtask

    task automatic check_bit(input logic act, input logic exp, input string name,
                             input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, name, act, exp, $time);
        end
    endtask

    // Monitor: compare at the falling edge, away from the active edge.
    initial begin
        logic [3:0] v;
        string t;
        forever begin
            @(negedge clk);
            if (q_val.size() != 0) begin
                v = q_val.pop_front();
                t = q_tag.pop_front();
                check_bit(col,      v[3], "col",      t);
                check_bit(crs,      v[2], "crs",      t);
                check_bit(tx_block, v[1], "tx_block", t);
                check_bit(sqe_req,  v[0], "sqe_req",  t);
            end
        end
    end

    // Watchdog
    initial begin
        #500000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        // R1 reset state
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 1, "R1");
        hold(2, 0, 0, 0, 0, 0, "R1");

        // R2 / R4 half duplex 10 Mb/s traffic, then heartbeat R10
        step(1, 0, 0, 0, 0, 0, "R4");
        hold(2, 1, 1, 0, 0, 0, "R2");
        step(1, 0, 0, 0, 0, 0, "R2");
        step(0, 1, 0, 0, 0, 0, "R4");
        hold(8, 0, 0, 0, 0, 0, "R10");

        // R11 early restart cancels the pending pulse
        hold(3, 1, 0, 0, 0, 0, "R11");
        hold(2, 0, 0, 0, 0, 0, "R11");
        hold(3, 1, 0, 0, 0, 0, "R11");
        hold(8, 0, 0, 0, 0, 0, "R10");

        // R3 full duplex: no collision, carrier from receive only
        hold(5, 1, 1, 1, 0, 0, "R3");
        step(1, 0, 1, 0, 0, 0, "R4");
        hold(8, 0, 0, 1, 0, 0, "R11");

        // R9 100 Mb/s: no timeout
        for (int i = 0; i < 30; i++) step(1, (i % 3) == 0, 0, 1, 0, 0, "R9");
        hold(8, 0, 0, 0, 1, 0, "R11");

        // R5 one short of the limit
        hold(JL - 1, 1, 0, 0, 0, 0, "R5");
        hold(8, 0, 0, 0, 0, 0, "R5");

        // R5 / R6 / R7 jabber set, held, restart, release
        hold(25, 1, 0, 0, 0, 0, "R5");
        for (int i = 0; i < 6; i++) step(1, i[0], 1, 0, 0, 0, "R6");
        hold(10, 0, 1, 0, 0, 0, "R7");
        hold(2, 1, 0, 0, 0, 0, "R7");
        hold(UL + 5, 0, 0, 0, 0, 0, "R7");

        // R8 watchdog off, then release by the control
        hold(40, 1, 0, 0, 0, 1, "R8");
        hold(5, 0, 0, 0, 0, 1, "R8");
        hold(JL + 2, 1, 0, 0, 0, 0, "R5");
        hold(2, 1, 0, 0, 0, 1, "R8");
        hold(8, 0, 0, 0, 0, 0, "R8");

        hold(4, 0, 0, 0, 0, 0, "R1");
        repeat (2) @(negedge clk);
        #1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule